// File: doc/BRIEF.md
# TDM Slot Transmit Serializer

This block takes data words from a valid/ready stream and sends them one bit at a time on a single serial data line. The slot and bit timing comes from an external bit clock and frame sync generator. That generator supplies a one-cycle `bit_tick` for every bit period and raises `frame_start` together with the tick that carries the first bit of a frame. A frame holds up to 32 word slots. Slot 0 has its own width, and every later slot shares a common width. Each slot either carries a data word or is left idle. A slot is idle when it is masked, when the channel is disabled, or when the transmitter is stalled after an underrun.

The bit order is set by two things: a first-bit index inside the word, and a most-significant-first or least-significant-first direction. An idle slot either releases the line (output enable low) or drives a zero, depending on the channel mode. Two sticky flags report events, and a one-cycle clear pulse resets each of them:
- A word-start flag marks the start of a chosen slot.
- An error flag marks an underrun.

After an underrun, the stream is taken up again in one of two ways:
- at slot 0 of a later frame, or
- at a later occurrence of the slot that starved.

In both cases this happens only once the error flag has been cleared.

Top module: `tdm_tx_serializer`

## Requirements
- R1: `sd_out` and `sd_oe` change only in the cycle after a cycle with `bit_tick` high. After reset, `sd_out`, `sd_oe`, `ws_flag` and `err_flag` are all 0.
- R2: Bit k of a slot (k = 0 is the first bit) carries word bit `(first_bit - k) mod 32` when `cfg_msb_first` = 1, and `(first_bit + k) mod 32` when it is 0.
- R3: A tick with `frame_start` high is bit 0 of slot 0. Slot 0 lasts `cfg_w0_last`+1 ticks, and every other slot lasts `cfg_wn_last`+1 ticks. The frame holds `cfg_frame_last`+1 slots. After the last slot the line is idle until the next `frame_start`.
- R4: Slot N is masked when bit N of `cfg_slot_mask` is 1. A masked slot takes no word (`in_ready` stays low) and is idle.
- R5: An idle bit drives `sd_out`=0. `sd_oe` is 1 for an idle bit when `cfg_out_zero`=1 and 0 when it is 0. A data bit always has `sd_oe`=1.
- R6: With `cfg_enable`=0 no word is taken, no flag is set, and the line is idle.
- R7: `in_ready` is high only in the tick cycle of bit 0 of an enabled, unmasked slot while not stalled. A word is taken when `in_valid` is also high, and its first bit appears in the next cycle.
- R8: When `in_ready` is high and `in_valid` is low, the slot is an underrun. `err_flag` is 1 from the next cycle, and the slot is idle.
- R9: With `cfg_resume_same`=0, no word is taken after an underrun until `err_flag` is clear. Words are then taken again starting at slot 0 of a frame.
- R10: With `cfg_resume_same`=1, no word is taken after an underrun until `err_flag` is clear. Words are then taken again starting at a slot whose index equals the index of the slot that starved.
- R11: `ws_flag` becomes 1 in the cycle after bit 0 of slot `cfg_ws_slot` starts on an enabled channel.
- R12: A one-cycle `clr_ws` or `clr_err` pulse clears its flag in the next cycle. If a set and a clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle pulse per serial bit period |
| frame_start | input | 1 | Marks the tick that carries bit 0 of slot 0 |
| cfg_enable | input | 1 | Channel enable |
| cfg_msb_first | input | 1 | 1: walk down from the first bit; 0: walk up |
| cfg_out_zero | input | 1 | Idle level: 1 drives zero, 0 releases the line |
| cfg_resume_same | input | 1 | Underrun recovery: 1 resumes at the same slot, 0 at slot 0 |
| cfg_first_bit | input | 5 | Word bit index sent first |
| cfg_w0_last | input | 5 | Slot 0 width minus one |
| cfg_wn_last | input | 5 | Width minus one of every other slot |
| cfg_frame_last | input | 5 | Slots per frame minus one |
| cfg_ws_slot | input | 5 | Slot index that sets the word-start flag |
| cfg_slot_mask | input | 32 | One mask bit per slot |
| in_data | input | 32 | Word to send |
| in_valid | input | 1 | Word available |
| in_ready | output | 1 | Word taken at this tick |
| clr_ws | input | 1 | Clear pulse for the word-start flag |
| clr_err | input | 1 | Clear pulse for the error flag |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Serial data output enable |
| ws_flag | output | 1 | Sticky word-start flag |
| err_flag | output | 1 | Sticky underrun flag |

## Verification
`in_ready` is combinational and is due in the same cycle as the tick. The bench therefore samples it one nanosecond after driving the tick inputs at a falling edge. The serial bit, the enable and both flags are registered on the tick edge and are due one cycle later, so the bench compares them at the next falling edge. At the falling edge after that, with no tick in between, it compares the line again to confirm that it held its value. A bench-side tick-level model tracks slot position, stall state and flags, and produces the expected values for each of these three sample points.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
    typedef enum logic {ORDER_UP = 1'b0, ORDER_DOWN = 1'b1} bit_order_e;
    typedef enum logic {IDLE_RELEASE = 1'b0, IDLE_DRIVE0 = 1'b1} idle_mode_e;
endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SLOTS  = 32,
    localparam int unsigned BIT_IW  = $clog2(DATA_W),
    localparam int unsigned SLOT_IW = $clog2(SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_tick,
    input  logic               frame_start,
    input  logic [BIT_IW-1:0]  w0_last,
    input  logic [BIT_IW-1:0]  wn_last,
    input  logic [SLOT_IW-1:0] frame_last,
    output logic               pos_valid,
    output logic               slot_start,
    output logic [SLOT_IW-1:0] cur_slot,
    output logic [BIT_IW-1:0]  cur_bit
);
    typedef struct packed {
        logic               in_frame;
        logic [SLOT_IW-1:0] slot;
        logic [BIT_IW-1:0]  bitpos;
    } pos_t;

    pos_t pos_q, pos_d;
    logic [BIT_IW-1:0] lim;

    always_comb begin
        pos_d     = pos_q;
        pos_valid = 1'b0;
        cur_slot  = pos_q.slot;
        cur_bit   = pos_q.bitpos;
        lim       = (pos_q.slot == '0) ? w0_last : wn_last;
        if (bit_tick) begin
            if (frame_start) begin
                cur_slot  = '0;
                cur_bit   = '0;
                pos_valid = 1'b1;
            end else if (pos_q.in_frame) begin
                if (pos_q.bitpos == lim) begin
                    if (pos_q.slot != frame_last) begin
                        cur_slot  = pos_q.slot + 1'b1;
                        cur_bit   = '0;
                        pos_valid = 1'b1;
                    end
                end else begin
                    cur_bit   = pos_q.bitpos + 1'b1;
                    pos_valid = 1'b1;
                end
            end
            pos_d.in_frame = pos_valid;
            pos_d.slot     = cur_slot;
            pos_d.bitpos   = cur_bit;
        end
        slot_start = pos_valid && (cur_bit == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    AST_FRAME_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick && frame_start |=> pos_q.in_frame && pos_q.slot == '0 && pos_q.bitpos == '0); // R3
endmodule

// File: rtl/tdm_sticky_flag.sv
module tdm_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_q, flag_d;

    always_comb begin
        flag_d = flag_q;
        if (clr) flag_d = 1'b0;
        if (set) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;

    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q && !clr |=> flag_q); // R12
endmodule

// File: rtl/tdm_bit_pick.sv
module tdm_bit_pick #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned BIT_IW = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] word,
    input  logic [BIT_IW-1:0] first,
    input  logic [BIT_IW-1:0] offset,
    input  logic              walk_down,
    output logic              bit_out
);
    logic [BIT_IW-1:0] up_idx, dn_idx;
    logic [DATA_W-1:0] onehot;

    assign up_idx = first + offset;
    assign dn_idx = first - offset;

    for (genvar i = 0; i < DATA_W; i++) begin : g_sel
        assign onehot[i] = word[i] && ((walk_down ? dn_idx : up_idx) == BIT_IW'(i));
    end

    assign bit_out = |onehot;
endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer
    import tdm_tx_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned SLOTS  = 32,
    localparam int unsigned BIT_IW  = $clog2(DATA_W),
    localparam int unsigned SLOT_IW = $clog2(SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_tick,
    input  logic               frame_start,
    input  logic               cfg_enable,
    input  logic               cfg_msb_first,
    input  logic               cfg_out_zero,
    input  logic               cfg_resume_same,
    input  logic [BIT_IW-1:0]  cfg_first_bit,
    input  logic [BIT_IW-1:0]  cfg_w0_last,
    input  logic [BIT_IW-1:0]  cfg_wn_last,
    input  logic [SLOT_IW-1:0] cfg_frame_last,
    input  logic [SLOT_IW-1:0] cfg_ws_slot,
    input  logic [SLOTS-1:0]   cfg_slot_mask,
    input  logic [DATA_W-1:0]  in_data,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               clr_ws,
    input  logic               clr_err,
    output logic               sd_out,
    output logic               sd_oe,
    output logic               ws_flag,
    output logic               err_flag
);
    typedef struct packed {
        logic [DATA_W-1:0]  word;
        logic               active;
        logic               halted;
        logic [SLOT_IW-1:0] stall;
        logic               sd;
        logic               oe;
    } tx_state_t;

    tx_state_t st_q, st_d;

    logic               pos_valid, slot_start;
    logic [SLOT_IW-1:0] cur_slot;
    logic [BIT_IW-1:0]  cur_bit;
    logic               start, resume_here, halted_now, eligible, underrun, ws_hit;
    logic               pick_bit;
    logic [DATA_W-1:0]  src_word;
    idle_mode_e         idle_mode;
    bit_order_e         order;

    tdm_slot_timer #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .frame_start(frame_start),
        .w0_last    (cfg_w0_last),
        .wn_last    (cfg_wn_last),
        .frame_last (cfg_frame_last),
        .pos_valid  (pos_valid),
        .slot_start (slot_start),
        .cur_slot   (cur_slot),
        .cur_bit    (cur_bit)
    );

    assign idle_mode = idle_mode_e'(cfg_out_zero);
    assign order     = bit_order_e'(cfg_msb_first);

    always_comb begin
        start       = slot_start && cfg_enable;
        resume_here = st_q.halted && !err_flag &&
                      (cfg_resume_same ? (cur_slot == st_q.stall) : (cur_slot == '0));
        halted_now  = st_q.halted && !resume_here;
        eligible    = start && !halted_now && !cfg_slot_mask[cur_slot];
        underrun    = eligible && !in_valid;
        ws_hit      = start && (cur_slot == cfg_ws_slot);
        src_word    = start ? in_data : st_q.word;
    end

    assign in_ready = eligible;

    tdm_bit_pick #(.DATA_W(DATA_W)) u_pick (
        .word     (src_word),
        .first    (cfg_first_bit),
        .offset   (cur_bit),
        .walk_down(order == ORDER_DOWN),
        .bit_out  (pick_bit)
    );

    always_comb begin
        st_d = st_q;
        if (bit_tick) begin
            if (start) begin
                if (resume_here) st_d.halted = 1'b0;
                st_d.active = eligible && in_valid;
                if (eligible && in_valid) st_d.word = in_data;
                if (underrun) begin
                    st_d.halted = 1'b1;
                    st_d.stall  = cur_slot;
                end
            end else begin
                st_d.active = st_q.active && pos_valid && cfg_enable;
            end
            if (st_d.active) begin
                st_d.sd = pick_bit;
                st_d.oe = 1'b1;
            end else begin
                st_d.sd = 1'b0;
                st_d.oe = (idle_mode == IDLE_DRIVE0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    tdm_sticky_flag u_ws_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (ws_hit),
        .clr  (clr_ws),
        .flag (ws_flag)
    );

    tdm_sticky_flag u_err_flag (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (underrun),
        .clr  (clr_err),
        .flag (err_flag)
    );

    assign sd_out = st_q.sd;
    assign sd_oe  = st_q.oe;

    AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(sd_out) && $stable(sd_oe)); // R1
    AST_DRIVE_ZERO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick && cfg_out_zero |=> sd_oe); // R5
    AST_UNDERRUN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready && !in_valid |=> err_flag); // R8
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_oe |-> !sd_out); // R5
endmodule

// File: tb/tdm_tx_serializer_bench.sv
module tdm_tx_serializer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 1'b0, frame_start = 1'b0;
    logic        cfg_enable = 1'b1, cfg_msb_first = 1'b1, cfg_out_zero = 1'b1, cfg_resume_same = 1'b0;
    logic [4:0]  cfg_first_bit = 5'd7, cfg_w0_last = 5'd7, cfg_wn_last = 5'd7;
    logic [4:0]  cfg_frame_last = 5'd3, cfg_ws_slot = 5'd1;
    logic [31:0] cfg_slot_mask = '0;
    logic [31:0] in_data = '0;
    logic        in_valid = 1'b0, clr_ws = 1'b0, clr_err = 1'b0;
    logic        in_ready, sd_out, sd_oe, ws_flag, err_flag;

    int errors = 0, checks = 0;
    int valid_pct = 100, clr_err_pct = 0, clr_ws_pct = 0;
    string scen = "R1 reset";

    // bench model state
    bit        m_in = 0, m_active = 0, m_halt = 0, m_sd = 0, m_oe = 0, m_ws = 0, m_err = 0;
    bit [4:0]  m_slot = 0, m_bit = 0, m_stall = 0;
    bit [31:0] m_word = 0;

    always #2.5 clk = ~clk;

    tdm_tx_serializer u_tdm_tx_serializer (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_start(frame_start),
        .cfg_enable(cfg_enable), .cfg_msb_first(cfg_msb_first), .cfg_out_zero(cfg_out_zero),
        .cfg_resume_same(cfg_resume_same), .cfg_first_bit(cfg_first_bit),
        .cfg_w0_last(cfg_w0_last), .cfg_wn_last(cfg_wn_last), .cfg_frame_last(cfg_frame_last),
        .cfg_ws_slot(cfg_ws_slot), .cfg_slot_mask(cfg_slot_mask), .in_data(in_data),
        .in_valid(in_valid), .in_ready(in_ready), .clr_ws(clr_ws), .clr_err(clr_err),
        .sd_out(sd_out), .sd_oe(sd_oe), .ws_flag(ws_flag), .err_flag(err_flag)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s (%s): got %0h expected %0h", tag, scen, got, exp);
        end
    endtask

    function automatic bit exp_bit(bit [31:0] w, bit [4:0] f, bit [4:0] k, bit down);
        bit [4:0] idx;
        idx = down ? f - k : f + k;
        return w[idx];
    endfunction

    task automatic one_tick(bit fs);
        bit pv, start, resume, elig, under, dv;
        bit [4:0] cs, cb, lim;
        bit ce, cw;
        // R1: line held through the non-tick cycle
        check("R1 sd_out", {31'd0, sd_out}, {31'd0, m_sd});
        check("R1 sd_oe", {31'd0, sd_oe}, {31'd0, m_oe});
        dv = ($urandom_range(99) < valid_pct);
        ce = ($urandom_range(99) < clr_err_pct);
        cw = ($urandom_range(99) < clr_ws_pct);
        bit_tick = 1'b1; frame_start = fs; in_valid = dv; in_data = $urandom;
        clr_err = ce; clr_ws = cw;
        #1;
        pv = 0; cs = m_slot; cb = m_bit;
        lim = (m_slot == 0) ? cfg_w0_last : cfg_wn_last;
        if (fs) begin cs = 0; cb = 0; pv = 1; end
        else if (m_in) begin
            if (m_bit == lim) begin
                if (m_slot != cfg_frame_last) begin cs = m_slot + 1; cb = 0; pv = 1; end
            end else begin cb = m_bit + 1; pv = 1; end
        end
        m_in = pv; m_slot = cs; m_bit = cb;
        start  = pv && cb == 0 && cfg_enable;
        resume = m_halt && !m_err && (cfg_resume_same ? cs == m_stall : cs == 0);
        elig   = start && !(m_halt && !resume) && !cfg_slot_mask[cs];
        under  = elig && !dv;
        check("R7 in_ready", {31'd0, in_ready}, {31'd0, elig});
        if (start) begin
            if (resume) m_halt = 0;
            m_active = elig && dv;
            if (elig && dv) m_word = in_data;
            if (under) begin m_halt = 1; m_stall = cs; end
        end else m_active = m_active && pv && cfg_enable;
        m_sd = m_active ? exp_bit(m_word, cfg_first_bit, cb, cfg_msb_first) : 1'b0;
        m_oe = m_active ? 1'b1 : cfg_out_zero;
        m_err = under || (m_err && !ce);
        m_ws  = (start && cs == cfg_ws_slot) || (m_ws && !cw);
        @(negedge clk);
        bit_tick = 1'b0; frame_start = 1'b0; in_valid = 1'b0; clr_err = 1'b0; clr_ws = 1'b0;
        check("R2 sd_out", {31'd0, sd_out}, {31'd0, m_sd});
        check("R5 sd_oe", {31'd0, sd_oe}, {31'd0, m_oe});
        check("R8 err_flag", {31'd0, err_flag}, {31'd0, m_err});
        check("R11 ws_flag", {31'd0, ws_flag}, {31'd0, m_ws});
        @(negedge clk);
    endtask

    task automatic run_frame(int extra);
        int n;
        n = (cfg_w0_last + 1) + cfg_frame_last * (cfg_wn_last + 1);
        one_tick(1'b1);
        for (int i = 1; i < n + extra; i++) one_tick(1'b0);
    endtask

    task automatic random_cfg();
        cfg_msb_first  = $urandom_range(1);
        cfg_out_zero   = $urandom_range(1);
        cfg_first_bit  = 5'($urandom_range(31));
        cfg_w0_last    = 5'($urandom_range(15, 1));
        cfg_wn_last    = 5'($urandom_range(15, 1));
        cfg_frame_last = 5'($urandom_range(7));
        cfg_ws_slot    = 5'($urandom_range(cfg_frame_last));
        cfg_slot_mask  = $urandom & $urandom;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 sd_out", {31'd0, sd_out}, 32'd0);
        check("R1 sd_oe", {31'd0, sd_oe}, 32'd0);
        check("R1 flags", {30'd0, ws_flag, err_flag}, 32'd0);
        check("R1 in_ready", {31'd0, in_ready}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        scen = "R3 R2 msb first, all valid";
        run_frame(3); run_frame(0);

        scen = "R2 lsb first";
        cfg_msb_first = 1'b0; cfg_first_bit = 5'd0; cfg_wn_last = 5'd11;
        run_frame(0);

        scen = "R4 R5 masked slots, release idle";
        cfg_out_zero = 1'b0; cfg_slot_mask = 32'h0000_0005;
        run_frame(2);

        scen = "R6 disabled";
        cfg_enable = 1'b0; valid_pct = 50;
        run_frame(1);
        cfg_enable = 1'b1;

        scen = "R9 underrun resume at frame start";
        cfg_slot_mask = '0; cfg_resume_same = 1'b0; valid_pct = 60; clr_err_pct = 8;
        for (int f = 0; f < 6; f++) run_frame(1);

        scen = "R10 underrun resume same slot";
        cfg_resume_same = 1'b1; cfg_frame_last = 5'd5;
        for (int f = 0; f < 6; f++) run_frame(1);

        scen = "R12 flag clears and set priority";
        valid_pct = 80; clr_ws_pct = 40; clr_err_pct = 40;
        for (int f = 0; f < 4; f++) run_frame(0);

        scen = "R3 random configs";
        clr_ws_pct = 10; clr_err_pct = 10;
        for (int f = 0; f < 30; f++) begin
            random_cfg();
            cfg_resume_same = $urandom_range(1);
            valid_pct = $urandom_range(100, 70);
            run_frame($urandom_range(3));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule